// File: doc/BRIEF.md
# Timing-Speculative Register Bank with Shadow Correction

This block holds a bank of data registers for a logic stage that is clocked faster than its worst-case path allows. Every bit is taken twice. A main register samples the combinational result on the early capture strobe, and the downstream logic uses that value at once. A shadow register samples the same result later, on a second strobe placed after the worst-case path has settled. A third strobe then compares the two copies bit by bit and records in an error register whether any pair disagrees.

While the error register is clear, the feedback bus returns the main register to the logic. When it is set, the feedback bus returns the shadow copy instead, so the next computation starts again from settled data. The first main capture after that clears the flag, which gives a single recovery cycle for each mismatch. Data sent to other modules always comes from the shadow copy. A hold input delays the error decision while an external detector reports an unresolved sample, and the decision is made once the hold drops. A wrapping counter records each evaluation that finds a mismatch.

All three strobes are clock enables sampled on the rising edge of `clk`. The reset is synchronous and active high.

Top module: `spec_regbank`

## Requirements
- R1: While `rst` is high at a rising edge, the main register, the shadow register, the error flag and the counter are all cleared. After that edge `fb_o`, `safe_o`, `err_o` and `err_cnt_o` read zero.
- R2: A rising edge with `main_stb_i` high loads `comb_i` into the main register. If `err_o` is 0 after that edge, `fb_o` shows the loaded value.
- R3: A rising edge with `shadow_stb_i` high loads `comb_i` into the shadow register. `safe_o` always equals the shadow register, so a main capture by itself leaves `safe_o` unchanged.
- R4: A rising edge with `err_stb_i` high and `meta_hold_i` low is an evaluation. After it, `err_o` is 1 if any bit of the main register differs from the same bit of the shadow register, and 0 otherwise.
- R5: While `err_o` is 1, `fb_o` equals the shadow copy, which is `safe_o`.
- R6: A rising edge with `main_stb_i` high and `err_o` high clears `err_o`, unless an evaluation happens at the same edge. In that case the evaluation result wins.
- R7: An `err_stb_i` pulse that arrives while `meta_hold_i` is high does not change `err_o`. The pulse is remembered, and the evaluation takes place at the first rising edge where `meta_hold_i` is low.
- R8: `err_cnt_o` increases by exactly one at each evaluation that finds a mismatch, and wraps modulo 2^CNT_W. Otherwise it keeps its value.
- R9: A mismatch in any single bit position, including the highest, is enough to set `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are enables on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| comb_i | input | DATA_W | Result bus from the combinational logic |
| main_stb_i | input | 1 | Early (speculative) capture strobe |
| shadow_stb_i | input | 1 | Late (settled) capture strobe |
| err_stb_i | input | 1 | Strobe that evaluates the comparison |
| meta_hold_i | input | 1 | Delays evaluation while high |
| fb_o | output | DATA_W | Feedback bus to the logic: main copy, or shadow copy during recovery |
| safe_o | output | DATA_W | Outgoing data, always the shadow copy |
| err_o | output | 1 | Registered error flag |
| err_cnt_o | output | CNT_W | Wrapping count of evaluations that found a mismatch |

## Verification
The bench builds the bank with DATA_W=4 and CNT_W=3. With four bits, every pair of main and shadow values (256 pairs) can be applied, which covers every single-bit mismatch, including one in the highest bit, as well as all multi-bit mismatches and all matches. With a three-bit counter, the 240 mismatching pairs wrap the count many times. The small width also makes it cheap to run a held evaluation, its postponed release and a mid-run reset from a state that is not zero.

// File: rtl/specbank_pkg.sv
package specbank_pkg;

  typedef struct packed {
    logic flag;
    logic pend;
  } err_state_t;

  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

endpackage

// File: rtl/specbank_capture.sv
module specbank_capture #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              main_stb,
  input  logic              shadow_stb,
  input  logic [DATA_W-1:0] comb_i,
  output logic [DATA_W-1:0] main_q,
  output logic [DATA_W-1:0] shadow_q,
  output logic [DATA_W-1:0] diff
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic m_r;
    logic s_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        m_r <= 1'b0;
      end else if (main_stb) begin
        m_r <= comb_i[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        s_r <= 1'b0;
      end else if (shadow_stb) begin
        s_r <= comb_i[i];
      end
    end

    assign main_q[i]   = m_r;
    assign shadow_q[i] = s_r;
    assign diff[i]     = m_r ^ s_r;
  end

endmodule

// File: rtl/specbank_or_tree.sv
module specbank_or_tree #(
  parameter int unsigned IN_W = 32
) (
  input  logic [IN_W-1:0] in_i,
  output logic            any_o
);
  import specbank_pkg::*;

  localparam int unsigned LEAVES = pow2_ceil(IN_W);
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic [NODES-1:0] node;

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < IN_W) begin : g_used
      assign node[LEAVES - 1 + j] = in_i[j];
    end else begin : g_pad
      assign node[LEAVES - 1 + j] = 1'b0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_inner
    assign node[k] = node[2*k + 1] | node[2*k + 2];
  end

  assign any_o = node[0];

endmodule

// File: rtl/specbank_err_ctrl.sv
module specbank_err_ctrl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_stb,
  input  logic             meta_hold,
  input  logic             main_stb,
  input  logic             mismatch,
  output logic             err_o,
  output logic [CNT_W-1:0] cnt_o
);
  import specbank_pkg::*;

  err_state_t       st;
  logic [CNT_W-1:0] cnt_r;
  logic             eval;

  assign eval = !meta_hold && (err_stb || st.pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= '0;
      cnt_r <= '0;
    end else begin
      if (meta_hold) begin
        st.pend <= st.pend | err_stb;
      end else begin
        st.pend <= 1'b0;
      end
      if (eval) begin
        st.flag <= mismatch;
        if (mismatch) begin
          cnt_r <= cnt_r + 1'b1;
        end
      end else if (main_stb && st.flag) begin
        st.flag <= 1'b0;
      end
    end
  end

  assign err_o = st.flag;
  assign cnt_o = cnt_r;

endmodule

// File: rtl/spec_regbank.sv
module spec_regbank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] comb_i,
  input  logic              main_stb_i,
  input  logic              shadow_stb_i,
  input  logic              err_stb_i,
  input  logic              meta_hold_i,
  output logic [DATA_W-1:0] fb_o,
  output logic [DATA_W-1:0] safe_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  err_cnt_o
);

  logic [DATA_W-1:0] main_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] diff;
  logic              mismatch;
  logic              err_flag;

  specbank_capture #(.DATA_W(DATA_W)) cap_i (
    .clk        (clk),
    .rst        (rst),
    .main_stb   (main_stb_i),
    .shadow_stb (shadow_stb_i),
    .comb_i     (comb_i),
    .main_q     (main_q),
    .shadow_q   (shadow_q),
    .diff       (diff)
  );

  specbank_or_tree #(.IN_W(DATA_W)) tree_i (
    .in_i  (diff),
    .any_o (mismatch)
  );

  specbank_err_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .err_stb   (err_stb_i),
    .meta_hold (meta_hold_i),
    .main_stb  (main_stb_i),
    .mismatch  (mismatch),
    .err_o     (err_flag),
    .cnt_o     (err_cnt_o)
  );

  assign fb_o   = err_flag ? shadow_q : main_q;
  assign safe_o = shadow_q;
  assign err_o  = err_flag;

endmodule

// File: rtl/spec_regbank_chk.sv
module spec_regbank_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] comb_i,
  input logic              main_stb_i,
  input logic              shadow_stb_i,
  input logic              err_stb_i,
  input logic              meta_hold_i,
  input logic [DATA_W-1:0] fb_o,
  input logic [DATA_W-1:0] safe_o,
  input logic              err_o,
  input logic [CNT_W-1:0]  err_cnt_o
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (err_o == 1'b0 && safe_o == '0 && fb_o == '0 && err_cnt_o == '0));

  assert_main_feedback_R2: assert property (@(posedge clk) disable iff (rst)
    main_stb_i |=> (err_o || fb_o == $past(comb_i)));

  assert_shadow_load_R3: assert property (@(posedge clk) disable iff (rst)
    shadow_stb_i |=> (safe_o == $past(comb_i)));

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !shadow_stb_i |=> $stable(safe_o));

  assert_recover_mux_R5: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (fb_o == safe_o));

  assert_hold_no_set_R7: assert property (@(posedge clk) disable iff (rst)
    (meta_hold_i && !err_o) |=> !err_o);

  assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (meta_hold_i && !main_stb_i) |=> $stable(err_o));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(err_cnt_o) || (err_o && err_cnt_o == $past(err_cnt_o) + 1'b1)));

endmodule

bind spec_regbank spec_regbank_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .comb_i       (comb_i),
  .main_stb_i   (main_stb_i),
  .shadow_stb_i (shadow_stb_i),
  .err_stb_i    (err_stb_i),
  .meta_hold_i  (meta_hold_i),
  .fb_o         (fb_o),
  .safe_o       (safe_o),
  .err_o        (err_o),
  .err_cnt_o    (err_cnt_o)
);

// File: tb/spec_regbank_tb_top.sv
`timescale 1ns/1ps
module spec_regbank_tb_top;
  localparam int DW = 4;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] comb_i = '0;
  logic          main_stb_i = 1'b0;
  logic          shadow_stb_i = 1'b0;
  logic          err_stb_i = 1'b0;
  logic          meta_hold_i = 1'b0;
  logic [DW-1:0] fb_o;
  logic [DW-1:0] safe_o;
  logic          err_o;
  logic [CW-1:0] err_cnt_o;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spec_regbank #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .comb_i(comb_i), .main_stb_i(main_stb_i),
    .shadow_stb_i(shadow_stb_i), .err_stb_i(err_stb_i), .meta_hold_i(meta_hold_i),
    .fb_o(fb_o), .safe_o(safe_o), .err_o(err_o), .err_cnt_o(err_cnt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    rst = 1'b0;
    chk("R1 fb", int'(fb_o), 0);
    chk("R1 safe", int'(safe_o), 0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 cnt", int'(err_cnt_o), 0);

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        bit prev_err;
        int prev_safe;
        prev_err  = err_o;
        prev_safe = int'(safe_o);
        comb_i = DW'(a); main_stb_i = 1'b1;
        tick();
        main_stb_i = 1'b0;
        if (prev_err) chk("R6 clear on main capture", int'(err_o), 0);
        chk("R3 safe unchanged by main capture", int'(safe_o), prev_safe);
        chk("R2 fb shows main", int'(fb_o), a);
        comb_i = DW'(b); shadow_stb_i = 1'b1;
        tick();
        shadow_stb_i = 1'b0;
        chk("R3 safe shows shadow", int'(safe_o), b);
        err_stb_i = 1'b1;
        tick();
        err_stb_i = 1'b0;
        if (a != b) exp_cnt = (exp_cnt + 1) % (1 << CW);
        if (((a ^ b) & (a ^ b) - 1) == 0 && a != b)
          chk("R9 single-bit mismatch", int'(err_o), 1);
        else
          chk("R4 evaluation", int'(err_o), (a != b) ? 1 : 0);
        chk("R8 count", int'(err_cnt_o), exp_cnt);
        chk("R5 fb during recovery", int'(fb_o), (a != b) ? b : a);
      end
    end

    // clear any pending error, then held evaluation
    comb_i = 4'd5; main_stb_i = 1'b1;
    tick();
    main_stb_i = 1'b0;
    chk("R6 clear before hold test", int'(err_o), 0);
    comb_i = 4'd6; shadow_stb_i = 1'b1;
    tick();
    shadow_stb_i = 1'b0;
    meta_hold_i = 1'b1; err_stb_i = 1'b1;
    tick();
    err_stb_i = 1'b0;
    chk("R7 no decision under hold", int'(err_o), 0);
    tick();
    tick();
    chk("R7 still frozen", int'(err_o), 0);
    chk("R7 count frozen", int'(err_cnt_o), exp_cnt);
    meta_hold_i = 1'b0;
    tick();
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    chk("R7 postponed decision", int'(err_o), 1);
    chk("R8 count after postponed decision", int'(err_cnt_o), exp_cnt);
    chk("R5 fb after postponed decision", int'(fb_o), 6);

    // mid-run reset from non-zero state
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 mid-run fb", int'(fb_o), 0);
    chk("R1 mid-run safe", int'(safe_o), 0);
    chk("R1 mid-run err", int'(err_o), 0);
    chk("R1 mid-run cnt", int'(err_cnt_o), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule